// File: doc/BRIEF.md
# Next-PC and Branch Control Unit

This block chooses the program counter for the next instruction. It resolves conditional branches against three condition flags (negative, zero, positive) that it keeps itself. It also handles register jumps, subroutine calls and table-vectored system calls. A sequencer pulses `issue` once for each instruction, together with the instruction word, the already incremented PC and the value of the register named in bits 8:6. The unit then answers with `pc_load`/`next_pc`, and for calls it answers with a request to write the return address into R7. The flags are loaded from any result that the datapath marks with `flag_we`.

A system call reads its new PC from a table in memory. The unit drives a read request for the vector address and then waits one cycle for the registered memory to return the word. It is built around a two-state machine:

- RUN: the idle state, which accepts instructions.
- VECTOR: the table word is arriving.

There are two transitions:

- RUN to VECTOR on an issued system call.
- VECTOR to RUN unconditionally after one cycle.

`busy` is high in both cycles of a system call. The sequencer must not advance while it is high, and an `issue` seen in VECTOR is discarded.

Top module: `npc_unit`

## Requirements
- R1: While reset is held and right after it, the flags read N=0 Z=1 P=0 (`cc` = 3'b010 as {N,Z,P}), the state is RUN, and `busy`, `pc_load`, `link_we` and `tbl_rd` are all 0.
- R2: On a clock edge with `flag_we`=1, `cc` becomes {value[15], value==0, value positive}, so exactly one bit is set. Without `flag_we`, `cc` holds.
- R3: Opcode 0000 (bits 15:12) is a conditional branch with mask bits 11:9 = {n,z,p}. If (mask & cc) is nonzero, `next_pc` = `pc_inc` + sign-extended bits 8:0; otherwise it is `pc_inc`. Mask 000 never branches and mask 111 always does. No link write occurs.
- R4: A branch tests the flags held before the edge, so a `flag_we` in the same cycle only affects later instructions.
- R5: Opcode 1100 is a register jump: `next_pc` = `base_val`, with no link write. A return is this jump with R7 as base.
- R6: Opcode 0100 with bit 11 = 1 is a relative call: `next_pc` = `pc_inc` + sign-extended bits 10:0, `link_we`=1 and `link_data` = `pc_inc`.
- R7: Opcode 0100 with bit 11 = 0 is a register call: `next_pc` = `base_val` sampled in the issue cycle, with `link_we`=1 and `link_data` = `pc_inc`. A call through R7 therefore jumps to the old R7.
- R8: Opcode 1111 is a system call. In the issue cycle the outputs are `tbl_rd`=1, `tbl_addr` = zero-extended bits 7:0, `link_we`=1 with `link_data` = `pc_inc`, `busy`=1 and `pc_load`=0. In the following cycle the outputs are `pc_load`=1, `next_pc` = `tbl_rdata` and `busy`=1; the state then returns to RUN.
- R9: An `issue` arriving in the VECTOR cycle is ignored: it raises neither `link_we` nor `tbl_rd`, and `next_pc` still comes from the table.
- R10: Any other opcode gives `pc_load`=1 with `next_pc` = `pc_inc` and no link write.
- R11: In RUN without `issue`, `pc_load`, `link_we` and `tbl_rd` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction valid for one cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the following instruction |
| base_val | input | 16 | Contents of the register named in bits 8:6 |
| flag_we | input | 1 | Load the flags from `flag_val` |
| flag_val | input | 16 | Result value that sets the flags |
| tbl_rdata | input | 16 | Table word, valid the cycle after `tbl_rd` |
| tbl_rd | output | 1 | Table read request |
| tbl_addr | output | 16 | Table read address |
| pc_load | output | 1 | `next_pc` is valid this cycle |
| next_pc | output | 16 | Selected program counter |
| link_we | output | 1 | Write return address into R7 |
| link_data | output | 16 | Return address |
| busy | output | 1 | System call in progress |
| cc | output | 3 | Flags {N,Z,P} |

## Verification
The assertions check several properties on every cycle:

- the flags always hold exactly one set bit and change only on `flag_we`;
- a table read is always followed by a PC load while busy, and is never issued twice in a row;
- nothing is loaded or linked while idle;
- a register jump always loads `base_val` without linking.

The branch decisions for all eight masks against each flag state, the sign extension of both offset sizes, and the same-cycle ordering between a flag update and a branch can only be shown by the bench's scenarios. The same holds for the R7 read-before-write order of a register call and for discarding an instruction issued during the vector cycle. The bench computes the expected value for each of these cases.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic {
        ST_RUN,
        ST_VECTOR
    } npc_state_t;

    typedef enum logic [1:0] {
        SRC_INC,
        SRC_REL,
        SRC_BASE,
        SRC_TABLE
    } pc_src_t;

    localparam logic [3:0] OP_BR   = 4'b0000;
    localparam logic [3:0] OP_CALL = 4'b0100;
    localparam logic [3:0] OP_JMP  = 4'b1100;
    localparam logic [3:0] OP_SYS  = 4'b1111;
endpackage

// File: rtl/npc_flags.sv
module npc_flags #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] val,
    output logic [2:0]   cc
);
    logic neg, zero;

    assign neg  = val[W-1];
    assign zero = (val == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc <= 3'b010;
        end else if (upd) begin
            cc <= {neg, zero, !neg && !zero};
        end
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W     = 16,
    parameter int OFS_S = 9,
    parameter int OFS_L = 11
) (
    input  pc_src_t          src,
    input  logic             long_ofs,
    input  logic [OFS_L-1:0] ofs_field,
    input  logic [W-1:0]     pc_inc,
    input  logic [W-1:0]     base_val,
    input  logic [W-1:0]     tbl_word,
    output logic [W-1:0]     target
);
    logic [W-1:0] ofs_short, ofs_long, ofs;

    assign ofs_short = {{(W-OFS_S){ofs_field[OFS_S-1]}}, ofs_field[OFS_S-1:0]};
    assign ofs_long  = {{(W-OFS_L){ofs_field[OFS_L-1]}}, ofs_field};
    assign ofs       = long_ofs ? ofs_long : ofs_short;

    always_comb begin
        unique case (src)
            SRC_INC:   target = pc_inc;
            SRC_REL:   target = pc_inc + ofs;
            SRC_BASE:  target = base_val;
            SRC_TABLE: target = tbl_word;
            default:   target = pc_inc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int W     = 16,
    parameter int VEC_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [15:0]  instr,
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] base_val,
    input  logic         flag_we,
    input  logic [W-1:0] flag_val,
    input  logic [W-1:0] tbl_rdata,
    output logic         tbl_rd,
    output logic [W-1:0] tbl_addr,
    output logic         pc_load,
    output logic [W-1:0] next_pc,
    output logic         link_we,
    output logic [W-1:0] link_data,
    output logic         busy,
    output logic [2:0]   cc
);
    localparam int OFS_S = 9;
    localparam int OFS_L = 11;

    npc_state_t state, state_nx;
    pc_src_t    src;
    logic       long_ofs;
    logic [3:0] opcode;
    logic       br_taken;

    assign opcode   = instr[15:12];
    assign br_taken = |(instr[11:9] & cc);

    npc_flags #(.W(W)) i_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (flag_we),
        .val  (flag_val),
        .cc   (cc)
    );

    npc_target #(.W(W), .OFS_S(OFS_S), .OFS_L(OFS_L)) i_target (
        .src      (src),
        .long_ofs (long_ofs),
        .ofs_field(instr[OFS_L-1:0]),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .tbl_word (tbl_rdata),
        .target   (next_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        src      = SRC_INC;
        long_ofs = 1'b0;
        pc_load  = 1'b0;
        link_we  = 1'b0;
        tbl_rd   = 1'b0;
        busy     = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (issue) begin
                    pc_load = 1'b1;
                    case (opcode)
                        OP_BR: begin
                            if (br_taken) src = SRC_REL;
                        end
                        OP_JMP: src = SRC_BASE;
                        OP_CALL: begin
                            link_we = 1'b1;
                            if (instr[11]) begin
                                src      = SRC_REL;
                                long_ofs = 1'b1;
                            end else begin
                                src = SRC_BASE;
                            end
                        end
                        OP_SYS: begin
                            pc_load  = 1'b0;
                            link_we  = 1'b1;
                            tbl_rd   = 1'b1;
                            busy     = 1'b1;
                            state_nx = ST_VECTOR;
                        end
                        default: src = SRC_INC;
                    endcase
                end
            end
            ST_VECTOR: begin
                pc_load  = 1'b1;
                busy     = 1'b1;
                src      = SRC_TABLE;
                state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    assign link_data = pc_inc;
    assign tbl_addr  = {{(W-VEC_W){1'b0}}, instr[VEC_W-1:0]};
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue,
    input logic [15:0]  instr,
    input logic [W-1:0] base_val,
    input logic         flag_we,
    input logic         tbl_rd,
    input logic         pc_load,
    input logic [W-1:0] next_pc,
    input logic         link_we,
    input logic         busy,
    input logic [2:0]   cc
);
    a_r2_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);

    a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(cc));

    a_r8_vector_load: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |=> (pc_load && busy));

    a_r9_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |=> (!tbl_rd && !link_we));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !busy) |-> (!pc_load && !link_we && !tbl_rd));

    a_r5_jump_base: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !busy && instr[15:12] == 4'b1100) |-> (pc_load && !link_we && next_pc == base_val));
endmodule

bind npc_unit npc_unit_chk #(.W(W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .instr   (instr),
    .base_val(base_val),
    .flag_we (flag_we),
    .tbl_rd  (tbl_rd),
    .pc_load (pc_load),
    .next_pc (next_pc),
    .link_we (link_we),
    .busy    (busy),
    .cc      (cc)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [15:0]  instr = '0;
    logic [W-1:0] pc_inc = '0, base_val = '0, flag_val = '0, tbl_rdata = '0;
    logic         flag_we = 1'b0;
    logic         tbl_rd, pc_load, link_we, busy;
    logic [W-1:0] tbl_addr, next_pc, link_data;
    logic [2:0]   cc;

    int checks = 0;
    int errors = 0;
    logic [2:0] m_cc = 3'b010;

    always #10 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .pc_inc(pc_inc),
        .base_val(base_val), .flag_we(flag_we), .flag_val(flag_val),
        .tbl_rdata(tbl_rdata), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr),
        .pc_load(pc_load), .next_pc(next_pc), .link_we(link_we),
        .link_data(link_data), .busy(busy), .cc(cc)
    );

    function automatic logic [15:0] f_tbl(input logic [15:0] a);
        return (a * 16'h02B5) ^ 16'h5A3C;
    endfunction

    function automatic logic [2:0] f_cc(input logic [15:0] v);
        return {v[15], v == 16'h0, !v[15] && v != 16'h0};
    endfunction

    always @(posedge clk) if (tbl_rd) tbl_rdata <= f_tbl(tbl_addr);

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic [15:0] ins, input logic [15:0] pci, input logic [15:0] base,
                        input logic fwe, input logic [15:0] fval, input string req);
        logic [3:0]  op;
        logic        e_load, e_link, e_tbl, e_busy;
        logic [15:0] e_pc;
        @(negedge clk);
        issue = 1'b1; instr = ins; pc_inc = pci; base_val = base; flag_we = fwe; flag_val = fval;
        #5;
        op = ins[15:12];
        e_load = 1'b1; e_link = 1'b0; e_tbl = 1'b0; e_busy = 1'b0; e_pc = pci;
        case (op)
            4'b0000: if (|(ins[11:9] & m_cc)) e_pc = pci + {{7{ins[8]}}, ins[8:0]};
            4'b1100: e_pc = base;
            4'b0100: begin
                e_link = 1'b1;
                e_pc = ins[11] ? pci + {{5{ins[10]}}, ins[10:0]} : base;
            end
            4'b1111: begin
                e_load = 1'b0; e_link = 1'b1; e_tbl = 1'b1; e_busy = 1'b1;
            end
            default: e_pc = pci;
        endcase
        chk(req, "pc_load", {15'h0, pc_load}, {15'h0, e_load});
        if (e_load) chk(req, "next_pc", next_pc, e_pc);
        chk(req, "link_we", {15'h0, link_we}, {15'h0, e_link});
        if (e_link) chk(req, "link_data", link_data, pci);
        chk(req, "tbl_rd", {15'h0, tbl_rd}, {15'h0, e_tbl});
        if (e_tbl) chk(req, "tbl_addr", tbl_addr, {8'h00, ins[7:0]});
        chk(req, "busy", {15'h0, busy}, {15'h0, e_busy});
        chk("R2", "cc", {13'h0, cc}, {13'h0, m_cc});
        @(posedge clk);
        if (fwe) m_cc = f_cc(fval);
        if (op == 4'b1111) begin
            // R8 second cycle; R9: a stray issue here must be discarded
            @(negedge clk);
            issue = $urandom_range(0, 1); instr = 16'h4800 | 16'($urandom_range(0, 2047));
            pc_inc = 16'($urandom); flag_we = $urandom_range(0, 1); flag_val = 16'($urandom);
            #5;
            chk("R8", "vec pc_load", {15'h0, pc_load}, 16'h1);
            chk("R8", "vec next_pc", next_pc, f_tbl({8'h00, ins[7:0]}));
            chk("R8", "vec busy", {15'h0, busy}, 16'h1);
            chk("R9", "vec link_we", {15'h0, link_we}, 16'h0);
            chk("R9", "vec tbl_rd", {15'h0, tbl_rd}, 16'h0);
            @(posedge clk);
            if (flag_we) m_cc = f_cc(flag_val);
        end
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        issue = 1'b0; flag_we = 1'b0; instr = 16'($urandom);
        #5;
        chk(req, "idle pc_load", {15'h0, pc_load}, 16'h0);
        chk(req, "idle link_we", {15'h0, link_we}, 16'h0);
        chk(req, "idle tbl_rd", {15'h0, tbl_rd}, 16'h0);
        chk(req, "idle busy", {15'h0, busy}, 16'h0);
        @(posedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) @(negedge clk);
        #5;
        chk("R1", "reset cc", {13'h0, cc}, 16'h2);
        chk("R1", "reset busy", {15'h0, busy}, 16'h0);
        chk("R1", "reset pc_load", {15'h0, pc_load}, 16'h0);
        chk("R1", "reset link_we", {15'h0, link_we}, 16'h0);
        chk("R1", "reset tbl_rd", {15'h0, tbl_rd}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R11");

        // R3: mask 000 never taken, mask 111 always taken, for every flag state
        for (int v = 0; v < 3; v++) begin
            logic [15:0] fv;
            fv = (v == 0) ? 16'h8001 : (v == 1) ? 16'h0000 : 16'h0042;
            step(16'h1000, 16'h3000, 16'h0, 1'b1, fv, "R2");
            step(16'h0005, 16'h3001, 16'h0, 1'b0, 16'h0, "R3");
            step(16'h0FF0, 16'h3002, 16'h0, 1'b0, 16'h0, "R3");
            for (int m = 1; m < 7; m++)
                step(16'(m << 9) | 16'h0100, 16'h3003, 16'h0, 1'b0, 16'h0, "R3");
        end
        // R4: flag update in the same cycle as the branch
        step(16'h1000, 16'h4000, 16'h0, 1'b1, 16'h0000, "R2");
        step(16'h0410, 16'h4001, 16'h0, 1'b1, 16'hFFFF, "R4");
        step(16'h0410, 16'h4002, 16'h0, 1'b0, 16'h0, "R4");
        // R5 jump and return through R7
        step(16'hC1C0, 16'h5000, 16'h1234, 1'b0, 16'h0, "R5");
        // R6 relative call, negative and positive offsets
        step(16'h4FFF, 16'h6000, 16'h0, 1'b0, 16'h0, "R6");
        step(16'h4C00, 16'h6000, 16'h0, 1'b0, 16'h0, "R6");
        step(16'h4BFF, 16'h6000, 16'h0, 1'b0, 16'h0, "R6");
        // R7 register call through R7
        step(16'h41C0, 16'h7000, 16'hBEEF, 1'b0, 16'h0, "R7");
        // R8/R9 system calls with edge vectors
        step(16'hF000, 16'h8000, 16'h0, 1'b0, 16'h0, "R8");
        step(16'hF0FF, 16'h8100, 16'h0, 1'b0, 16'h0, "R8");
        // R10 other opcode
        step(16'h1234, 16'h9000, 16'h5555, 1'b1, 16'h7000, "R10");
        idle("R11");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] ins;
            int sel;
            sel = $urandom_range(0, 4);
            ins = 16'($urandom);
            case (sel)
                0: ins[15:12] = 4'b0000;
                1: ins[15:12] = 4'b1100;
                2: ins[15:12] = 4'b0100;
                3: ins = {8'hF0, ins[7:0]};
                default: ;
            endcase
            step(ins, 16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)), 16'($urandom),
                 (sel == 0) ? "R3" : (sel == 1) ? "R5" : (sel == 2) ? (ins[11] ? "R6" : "R7") :
                 (sel == 3) ? "R8" : "R10");
            if ($urandom_range(0, 7) == 0) idle("R11");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule